// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Block

This block holds a down-counting watchdog and the few registers that steer it, reached through a simple byte-addressed register port. Software sets a 10-bit reload value and then writes a reload strobe register to restart the countdown. The counter steps down by one on each pulse of an external coarse tick enable, but only while the system power-state input reports the full-on state. When the count steps from one to zero, the block emits a single-cycle timeout pulse and then stays at zero until the next restart.

Two other registers share the port. An 8-bit progress byte is driven straight out to a management messaging path. It lives in a separate always-powered reset domain, so a platform reset leaves it intact. A two-bit enable register masks two legacy interrupt lines before they go on.

Reads return data combinationally for the address presented. Writes take effect on the next clock edge. Each reset input is asserted asynchronously and released through its own two-stage synchroniser.

Top module: `wdog_regblk`

## Requirements
- R1: After core reset, reading offset 12h returns 0004h, offset 10h returns 0003h and offset 00h returns 0004h. After resume reset, offset 0Eh reads 00h and `status_out` is 00h. `timeout` is low after reset.
- R2: A write to offset 12h stores `wdata[9:0]` as the reload value. Bits 15:10 of that register always read as zero.
- R3: A write to offset 12h whose bits 9:0 equal 0 or 1 leaves the stored reload value unchanged.
- R4: A write of any data to offset 00h loads the counter with the stored reload value. Reading offset 00h returns the current count, zero-extended.
- R5: While `pwr_full_on` is 1 (the full-on state), each cycle with `tick_en` high lowers a nonzero count by one.
- R6: While `pwr_full_on` is 0, ticks leave the count unchanged. The input passes through a two-flop synchroniser before it gates counting.
- R7: When a tick takes the count from 1 to 0, `timeout` is high for exactly the following cycle. After that the count stays at 0, and further ticks raise no pulse.
- R8: Offset 0Eh is a read/write byte (`wdata[7:0]`), and its value is driven on `status_out`.
- R9: Core reset does not change the byte at offset 0Eh. Only `resume_rst_n` clears it.
- R10: Offset 10h bit 0 gates `irq1_raw` onto `irq1_gated`, and bit 1 gates `irq12_raw` onto `irq12_gated`, each by logical AND. Bits 15:2 read as zero.
- R11: A reload write in the same cycle as a tick loads the reload value, and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Platform reset, active low, asynchronous assert |
| resume_rst_n | input | 1 | Always-on domain reset, active low, clears the status byte only |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Coarse countdown tick, one cycle per step |
| pwr_full_on | input | 1 | 1 when the system is in the full-on power state |
| irq1_raw | input | 1 | Incoming interrupt line 1 |
| irq12_raw | input | 1 | Incoming interrupt line 12 |
| irq1_gated | output | 1 | Line 1 after masking by enable bit 0 |
| irq12_gated | output | 1 | Line 12 after masking by enable bit 1 |
| status_out | output | 8 | Progress byte for the management message |
| timeout | output | 1 | One-cycle pulse on expiry |

## Verification
The hardest state to reach is one where the two reset domains disagree. A status byte has to survive a core reset that returns every other register to its default. The stimulus writes a distinctive byte, pulses only the core reset, and then reads both the status byte and the reload register back. Expiry needs a short reload value so the one-to-zero step happens within a few ticks, and ticks must not coincide with a reload. The power gate is covered by leaving `pwr_full_on` low for longer than the synchroniser delay before ticking. A reload in the same cycle as a tick is driven together in one write cycle.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  // Register byte offsets; software depends on these positions
  localparam logic [7:0] OFF_RELOAD = 8'h00;
  localparam logic [7:0] OFF_STATUS = 8'h0E;
  localparam logic [7:0] OFF_GATE   = 8'h10;
  localparam logic [7:0] OFF_INIT   = 8'h12;

  localparam int IRQ_N = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RELOAD,
    SEL_STATUS,
    SEL_GATE,
    SEL_INIT
  } reg_sel_e;
endpackage

// File: rtl/wdog_rst_sync.sv
`timescale 1ns/1ps
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_bit_sync.sv
`timescale 1ns/1ps
module wdog_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] flop_q;
  logic [STAGES-1:0] flop_d;

  always_comb begin
    flop_d = {flop_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flop_q <= '0;
    else        flop_q <= flop_d;
  end

  assign q = flop_q[STAGES-1];
endmodule

// File: rtl/wdog_cfg_regs.sv
`timescale 1ns/1ps
module wdog_cfg_regs #(
  parameter int          CNT_W    = 10,
  parameter int          IRQ_N    = 2,
  parameter logic [CNT_W-1:0] INIT_RST = 10'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_init,
  input  logic [CNT_W-1:0] init_wdata,
  input  logic             wr_gate,
  input  logic [IRQ_N-1:0] gate_wdata,
  output logic [CNT_W-1:0] init_q,
  output logic [IRQ_N-1:0] gate_q
);
  logic             init_en;
  logic             gate_en;
  logic [CNT_W-1:0] init_d;
  logic [IRQ_N-1:0] gate_d;

  // Values below two are refused; the stored value stays as it was
  always_comb begin
    init_en = wr_init && (init_wdata > CNT_W'(1));
    init_d  = init_wdata;
    gate_en = wr_gate;
    gate_d  = gate_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       init_q <= INIT_RST;
    else if (init_en) init_q <= init_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= '1;
    else if (gate_en) gate_q <= gate_d;
  end
endmodule

// File: rtl/wdog_status_reg.sv
`timescale 1ns/1ps
module wdog_status_reg #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_d;

  always_comb stat_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= '0;
    else if (wr_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int               CNT_W   = 10,
  parameter logic [CNT_W-1:0] RST_VAL = 10'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             step;
  logic             expire_d;

  always_comb begin
    step     = tick && run && (cnt_q != '0);
    cnt_en   = load || step;
    cnt_d    = cnt_q;
    expire_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d    = cnt_q - CNT_W'(1);
      expire_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expire_q <= 1'b0;
    else        expire_q <= expire_d;
  end
endmodule

// File: rtl/wdog_regblk.sv
`timescale 1ns/1ps
module wdog_regblk
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 10,
  parameter int STAT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INIT_RST    = 4
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              resume_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  input  logic              pwr_full_on,
  input  logic              irq1_raw,
  input  logic              irq12_raw,
  output logic              irq1_gated,
  output logic              irq12_gated,
  output logic [STAT_W-1:0] status_out,
  output logic              timeout
);
  localparam logic [CNT_W-1:0] INIT_RST_V = CNT_W'(INIT_RST);

  logic             core_rst_s_n;
  logic             resume_rst_s_n;
  logic             pwr_ok;
  reg_sel_e         sel;
  logic             wr_reload;
  logic             wr_status;
  logic             wr_gate;
  logic             wr_init;
  logic [CNT_W-1:0] init_q;
  logic [IRQ_N-1:0] gate_q;
  logic [CNT_W-1:0] count_q;
  logic [STAT_W-1:0] stat_q;
  logic [IRQ_N-1:0] irq_raw;
  logic [IRQ_N-1:0] irq_out;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_core_rst (
    .clk(clk), .arst_n(core_rst_n), .srst_n(core_rst_s_n));

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_resume_rst (
    .clk(clk), .arst_n(resume_rst_n), .srst_n(resume_rst_s_n));

  wdog_bit_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
    .clk(clk), .rst_n(core_rst_s_n), .d(pwr_full_on), .q(pwr_ok));

  // Address decode
  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFF_RELOAD)) sel = SEL_RELOAD;
    else if (bus_addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(OFF_GATE))   sel = SEL_GATE;
    else if (bus_addr == ADDR_W'(OFF_INIT))   sel = SEL_INIT;
  end

  always_comb begin
    wr_reload = bus_wr && (sel == SEL_RELOAD);
    wr_status = bus_wr && (sel == SEL_STATUS);
    wr_gate   = bus_wr && (sel == SEL_GATE);
    wr_init   = bus_wr && (sel == SEL_INIT);
  end

  wdog_cfg_regs #(.CNT_W(CNT_W), .IRQ_N(IRQ_N), .INIT_RST(INIT_RST_V)) u_cfg (
    .clk       (clk),
    .rst_n     (core_rst_s_n),
    .wr_init   (wr_init),
    .init_wdata(bus_wdata[CNT_W-1:0]),
    .wr_gate   (wr_gate),
    .gate_wdata(bus_wdata[IRQ_N-1:0]),
    .init_q    (init_q),
    .gate_q    (gate_q)
  );

  wdog_status_reg #(.STAT_W(STAT_W)) u_status (
    .clk   (clk),
    .rst_n (resume_rst_s_n),
    .wr_en (wr_status),
    .wdata (bus_wdata[STAT_W-1:0]),
    .stat_q(stat_q)
  );

  wdog_counter #(.CNT_W(CNT_W), .RST_VAL(INIT_RST_V)) u_cnt (
    .clk     (clk),
    .rst_n   (core_rst_s_n),
    .load    (wr_reload),
    .load_val(init_q),
    .tick    (tick_en),
    .run     (pwr_ok),
    .cnt_q   (count_q),
    .expire_q(timeout)
  );

  // Interrupt masking, one AND per legacy line
  assign irq_raw = {irq12_raw, irq1_raw};
  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq_gate
    assign irq_out[g] = irq_raw[g] & gate_q[g];
  end
  assign irq1_gated  = irq_out[0];
  assign irq12_gated = irq_out[1];

  assign status_out = stat_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_RELOAD: bus_rdata = DATA_W'(count_q);
      SEL_STATUS: bus_rdata = DATA_W'(stat_q);
      SEL_GATE:   bus_rdata = DATA_W'(gate_q);
      SEL_INIT:   bus_rdata = DATA_W'(init_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_regblk_chk.sv
`timescale 1ns/1ps
module wdog_regblk_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              core_rst_s_n,
  input logic              wr_init,
  input logic              wr_reload,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  init_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              tick_en,
  input logic              pwr_ok,
  input logic              timeout,
  input logic              irq1_raw,
  input logic              irq1_gated,
  input logic              irq12_raw,
  input logic              irq12_gated
);
  assert_init_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    (bus_addr == ADDR_W'(8'h12)) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

  assert_init_reject_small_R3: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    (wr_init && (bus_wdata[CNT_W-1:0] < CNT_W'(2))) |=> $stable(init_q));

  assert_reload_loads_R4: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    wr_reload |=> (count_q == $past(init_q)));

  assert_tick_step_R5: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    (tick_en && pwr_ok && !wr_reload && (count_q != '0)) |=> (count_q == $past(count_q) - CNT_W'(1)));

  assert_power_hold_R6: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    (!pwr_ok && !wr_reload) |=> $stable(count_q));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    timeout |=> !timeout);

  assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    timeout |-> (count_q == '0));

  assert_irq1_masked_R10: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    irq1_gated |-> irq1_raw);

  assert_irq12_masked_R10: assert property (@(posedge clk) disable iff (!core_rst_s_n)
    irq12_gated |-> irq12_raw);
endmodule

bind wdog_regblk wdog_regblk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .core_rst_s_n(core_rst_s_n),
  .wr_init     (wr_init),
  .wr_reload   (wr_reload),
  .bus_wdata   (bus_wdata),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .init_q      (init_q),
  .count_q     (count_q),
  .tick_en     (tick_en),
  .pwr_ok      (pwr_ok),
  .timeout     (timeout),
  .irq1_raw    (irq1_raw),
  .irq1_gated  (irq1_gated),
  .irq12_raw   (irq12_raw),
  .irq12_gated (irq12_gated)
);

// File: tb/wdog_regblk_tb_top.sv
`timescale 1ns/1ps
module wdog_regblk_tb_top;
  localparam int K_RD  = 0;
  localparam int K_TO  = 1;
  localparam int K_ST  = 2;
  localparam int K_I1  = 3;
  localparam int K_I12 = 4;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk;
  logic        core_rst_n;
  logic        resume_rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tick_en;
  logic        pwr_full_on;
  logic        irq1_raw;
  logic        irq12_raw;
  logic        irq1_gated;
  logic        irq12_gated;
  logic [7:0]  status_out;
  logic        timeout;

  int    checks;
  int    errors;
  bit    done;
  item_t sb_q[$];

  wdog_regblk dut_i (
    .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .pwr_full_on(pwr_full_on),
    .irq1_raw(irq1_raw), .irq12_raw(irq12_raw),
    .irq1_gated(irq1_gated), .irq12_gated(irq12_gated),
    .status_out(status_out), .timeout(timeout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: drains expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_TO:    act = {15'd0, timeout};
          K_ST:    act = {8'd0, status_out};
          K_I1:    act = {15'd0, irq1_gated};
          default: act = {15'd0, irq12_gated};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_now(input int kind, input logic [15:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic rd_now(input logic [7:0] a, input logic [15:0] exp, input string req);
    bus_addr = a;
    expect_now(K_RD, exp, req);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_now(a, exp, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic tk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    core_rst_n = 1'b0; resume_rst_n = 1'b0;
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 16'h0000;
    tick_en = 1'b0; pwr_full_on = 1'b1; irq1_raw = 1'b0; irq12_raw = 1'b0;
    idle(3);
    core_rst_n = 1'b1; resume_rst_n = 1'b1;
    idle(5);

    // R1: defaults
    rd(8'h12, 16'h0004, "R1");
    rd(8'h10, 16'h0003, "R1");
    rd(8'h0E, 16'h0000, "R1");
    rd(8'h00, 16'h0004, "R1");
    expect_now(K_ST, 16'h0000, "R1");
    expect_now(K_TO, 16'h0000, "R1");

    // R10: interrupt masking
    @(negedge clk);
    irq1_raw = 1'b1; irq12_raw = 1'b1;
    expect_now(K_I1, 16'h1, "R10");
    expect_now(K_I12, 16'h1, "R10");
    wr(8'h10, 16'h0002, 1'b0);
    expect_now(K_I1, 16'h0, "R10");
    expect_now(K_I12, 16'h1, "R10");
    wr(8'h10, 16'h0001, 1'b0);
    expect_now(K_I1, 16'h1, "R10");
    expect_now(K_I12, 16'h0, "R10");
    rd(8'h10, 16'h0001, "R10");
    wr(8'h10, 16'hFFFF, 1'b0);
    rd(8'h10, 16'h0003, "R10");
    @(negedge clk);
    irq1_raw = 1'b0;
    expect_now(K_I1, 16'h0, "R10");

    // R2: reload value with reserved bits
    wr(8'h12, 16'hFC07, 1'b0);
    rd(8'h12, 16'h0007, "R2");

    // R3: refused values
    wr(8'h12, 16'h0000, 1'b0);
    rd(8'h12, 16'h0007, "R3");
    wr(8'h12, 16'h0001, 1'b0);
    rd(8'h12, 16'h0007, "R3");
    wr(8'h12, 16'h0400, 1'b0);
    rd(8'h12, 16'h0007, "R3");

    // R4: restart loads counter
    wr(8'h00, 16'h0000, 1'b0);
    rd(8'h00, 16'h0007, "R4");

    // R5: ticks in full-on
    tick();
    rd_now(8'h00, 16'h0006, "R5");
    tick();
    tick();
    rd_now(8'h00, 16'h0004, "R5");

    // R6: power gate
    pwr_full_on = 1'b0;
    idle(4);
    tick();
    tick();
    rd_now(8'h00, 16'h0004, "R6");
    pwr_full_on = 1'b1;
    idle(4);

    // R11: reload and tick together
    wr(8'h00, 16'h0000, 1'b1);
    rd_now(8'h00, 16'h0007, "R11");

    // R7: expiry pulse and hold
    wr(8'h12, 16'h0002, 1'b0);
    wr(8'h00, 16'h0000, 1'b0);
    rd_now(8'h00, 16'h0002, "R7");
    tick();
    rd_now(8'h00, 16'h0001, "R7");
    expect_now(K_TO, 16'h0, "R7");
    tick();
    rd_now(8'h00, 16'h0000, "R7");
    expect_now(K_TO, 16'h1, "R7");
    @(negedge clk);
    expect_now(K_TO, 16'h0, "R7");
    tick();
    rd_now(8'h00, 16'h0000, "R7");
    expect_now(K_TO, 16'h0, "R7");

    // R8: status byte
    wr(8'h0E, 16'hFF5A, 1'b0);
    rd(8'h0E, 16'h005A, "R8");
    expect_now(K_ST, 16'h005A, "R8");

    // R9: core reset keeps status, resume reset clears it
    @(negedge clk);
    core_rst_n = 1'b0;
    idle(2);
    core_rst_n = 1'b1;
    idle(4);
    rd(8'h0E, 16'h005A, "R9");
    expect_now(K_ST, 16'h005A, "R9");
    rd(8'h12, 16'h0004, "R9");
    @(negedge clk);
    resume_rst_n = 1'b0;
    idle(2);
    resume_rst_n = 1'b1;
    idle(4);
    rd(8'h0E, 16'h0000, "R9");
    expect_now(K_ST, 16'h0000, "R9");

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule